// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command interpreter of a byte-wide parallel NOR flash with a 17-bit address. It watches single-cycle write strobes on the system clock and matches multi-cycle command sequences. Each sequence opens with the same two-write unlock prefix. From the matched sequence it steers the device between read-array, ID query (autoselect), program, chip erase, sector erase and erase suspend. Its outputs are the current mode, the latched program target and byte, the erase target, a one-cycle start pulse for the array, and the ID and protect-status byte that the bus reads in ID-query mode.

The array engine reports the end of a program or erase with a single-cycle `op_done` pulse. Only the low twelve address bits take part in unlock and command matching. Bits 16 to 12 name a sector. A partial sequence is dropped in three cases: a write that does not fit the sequence, the reset command (F0h), or a gap between two writes longer than `TMO_CYC` clock cycles.

Top module: `flcmd_decoder`

## Requirements
- R1: After a synchronous reset, `mode` is 0 (read array), `start_pulse` is 0 and `as_data` is 00h. A plain read needs no command.
- R2: The writes AAh@555h, 55h@2AAh, 90h@555h, issued from read-array mode, set `mode` to 1 (ID query). In that mode `as_data` is 37h when `rd_addr[11:0]` is 000h, A1h when it is 001h (TOP_BOOT=1; 4Ch otherwise) and 7Fh when it is 003h. Any other offset except 002h gives 00h. In every other mode `as_data` is 00h.
- R3: In ID-query mode with `rd_addr[11:0]` = 002h, `as_data` is 01h when `sect_prot[rd_addr[16:12]]` is set, and 00h when it is clear.
- R4: A write of F0h at any address returns ID-query mode to mode 0 and discards any partial sequence. In ID-query mode, every other write is ignored.
- R5: Unlock, then A0h@555h, then one more write gives `mode` 2 (program). That last write loads its address into `prog_addr` and its data into `prog_data`, and `start_pulse` is high for exactly the cycle after it.
- R6: Unlock, 80h@555h, unlock, then 10h@555h gives `mode` 3 with `erase_chip`=1. If the sixth write is 30h at any address instead, the result is `mode` 3 with `erase_chip`=0 and `erase_sect` taken from address bits 16:12. Either form pulses `start_pulse`.
- R7: In mode 3, B0h at any address gives mode 4 (suspended). In mode 4, 30h at any address gives mode 3 again. In mode 0, a lone 30h leaves the mode unchanged.
- R8: A sequence continues while the gap between consecutive strobes is at most `TMO_CYC` clock cycles. A longer gap abandons the partial sequence.
- R9: A write that does not match the next expected address/data pair discards the partial sequence and leaves the mode unchanged. Address bits 16:12 are ignored on unlock and command cycles.
- R10: In mode 4, a program sequence is accepted (mode 5, `start_pulse`) only when the erase is a sector erase and the target's bits 16:12 differ from `erase_sect`. Otherwise it is discarded and the mode stays at 4. `op_done` in mode 5 returns to mode 4.
- R11: `op_done` returns modes 2 and 3 to mode 0 and has no effect in modes 0, 1 and 4. When `op_done` and a write fall in the same cycle, `op_done` takes effect and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| op_done | input | 1 | Array finished the current program or erase |
| rd_addr | input | ADDR_W | Read address for ID-query data |
| sect_prot | input | 2**(ADDR_W-12) | Protect flag per sector |
| mode | output | 3 | 0 read, 1 ID query, 2 program, 3 erase, 4 suspended, 5 program in suspend |
| prog_addr | output | ADDR_W | Latched program address |
| prog_data | output | 8 | Latched program byte |
| erase_chip | output | 1 | Erase target is the whole array |
| erase_sect | output | ADDR_W-12 | Erase target sector |
| start_pulse | output | 1 | One-cycle start request to the array |
| as_data | output | 8 | ID-query read data |

## Verification
Two events can arrive in the same cycle: the array's end-of-operation pulse and a write that would change the mode, such as a suspend (B0h) during an erase. The bench raises `op_done` and a B0h strobe on the same clock edge during a sector erase. The outcome must be mode 0, with no move to the suspended state. The behavioural reference model applies the same priority every cycle, so the same ordering question is also judged in every other cycle of the run.

// File: rtl/flcmd_pkg.sv
package flcmd_pkg;

    localparam int LO_W   = 12;
    localparam int DATA_W = 8;

    localparam logic [LO_W-1:0] KEY_A = 12'h555;
    localparam logic [LO_W-1:0] KEY_B = 12'h2AA;

    localparam logic [DATA_W-1:0] C_UNLK1  = 8'hAA;
    localparam logic [DATA_W-1:0] C_UNLK2  = 8'h55;
    localparam logic [DATA_W-1:0] C_IDQ    = 8'h90;
    localparam logic [DATA_W-1:0] C_PROG   = 8'hA0;
    localparam logic [DATA_W-1:0] C_ERASE  = 8'h80;
    localparam logic [DATA_W-1:0] C_CHIP   = 8'h10;
    localparam logic [DATA_W-1:0] C_SECT   = 8'h30;
    localparam logic [DATA_W-1:0] C_SUSP   = 8'hB0;
    localparam logic [DATA_W-1:0] C_RESET  = 8'hF0;

    localparam logic [DATA_W-1:0] ID_MFR   = 8'h37;
    localparam logic [DATA_W-1:0] ID_TOP   = 8'hA1;
    localparam logic [DATA_W-1:0] ID_BOT   = 8'h4C;
    localparam logic [DATA_W-1:0] ID_CONT  = 8'h7F;

    typedef enum logic [2:0] {
        M_READ      = 3'd0,
        M_IDQ       = 3'd1,
        M_PROG      = 3'd2,
        M_ERASE     = 3'd3,
        M_SUSP      = 3'd4,
        M_SUSP_PROG = 3'd5
    } fl_mode_e;

    typedef enum logic [2:0] {
        S_IDLE, S_U1, S_U2, S_PD, S_E3, S_E4, S_E5
    } fl_step_e;

    function automatic logic pair_hit(input logic [LO_W-1:0] lo, input logic [DATA_W-1:0] d,
                                      input logic [LO_W-1:0] key, input logic [DATA_W-1:0] code);
        return (lo == key) && (d == code);
    endfunction

endpackage

// File: rtl/flcmd_gap.sv
module flcmd_gap #(
    parameter int TMO_CYC = 12500
) (
    input  logic clk,
    input  logic rst,
    input  logic armed,
    input  logic restart,
    output logic expire
);
    localparam int CNT_W = $clog2(TMO_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TMO_CYC - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart || !armed)
            cnt <= '0;
        else if (cnt != LAST)
            cnt <= cnt + 1'b1;
    end

    assign expire = armed && (cnt == LAST);

endmodule

// File: rtl/flcmd_seq.sv
module flcmd_seq
    import flcmd_pkg::*;
#(
    parameter int ADDR_W  = 17,
    parameter int TMO_CYC = 12500
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_stb,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     op_done,
    output fl_mode_e                 mode_q,
    output logic [ADDR_W-1:0]        pa_q,
    output logic [DATA_W-1:0]        pd_q,
    output logic                     ec_q,
    output logic [ADDR_W-LO_W-1:0]   es_q,
    output logic                     start_q
);
    localparam int SW = ADDR_W - LO_W;

    fl_step_e step_q, step_n;
    fl_mode_e mode_n;
    logic [ADDR_W-1:0] pa_n;
    logic [DATA_W-1:0] pd_n;
    logic ec_n, start_n;
    logic [SW-1:0] es_n;
    logic expire;
    logic [LO_W-1:0] lo;
    logic [SW-1:0] hi;

    assign lo = wr_addr[LO_W-1:0];
    assign hi = wr_addr[ADDR_W-1:LO_W];

    flcmd_gap #(.TMO_CYC(TMO_CYC)) i_gap (
        .clk(clk), .rst(rst),
        .armed(step_q != S_IDLE),
        .restart(wr_stb),
        .expire(expire)
    );

    always_comb begin
        mode_n  = mode_q;
        step_n  = step_q;
        pa_n    = pa_q;
        pd_n    = pd_q;
        ec_n    = ec_q;
        es_n    = es_q;
        start_n = 1'b0;
        if (op_done && (mode_q == M_PROG || mode_q == M_ERASE)) begin
            mode_n = M_READ;
            step_n = S_IDLE;
        end else if (op_done && mode_q == M_SUSP_PROG) begin
            mode_n = M_SUSP;
            step_n = S_IDLE;
        end else if (wr_stb) begin
            step_n = S_IDLE;
            if (step_q == S_PD) begin
                if (mode_q == M_READ || (mode_q == M_SUSP && !ec_q && hi != es_q)) begin
                    mode_n  = (mode_q == M_READ) ? M_PROG : M_SUSP_PROG;
                    pa_n    = wr_addr;
                    pd_n    = wr_data;
                    start_n = 1'b1;
                end
            end else if (wr_data == C_RESET) begin
                if (mode_q == M_IDQ) mode_n = M_READ;
            end else if (mode_q == M_ERASE) begin
                if (wr_data == C_SUSP) mode_n = M_SUSP;
            end else if (mode_q == M_SUSP && wr_data == C_SECT) begin
                mode_n = M_ERASE;
            end else if (mode_q == M_READ || mode_q == M_SUSP) begin
                unique case (step_q)
                    S_IDLE: if (pair_hit(lo, wr_data, KEY_A, C_UNLK1)) step_n = S_U1;
                    S_U1:   if (pair_hit(lo, wr_data, KEY_B, C_UNLK2)) step_n = S_U2;
                    S_U2: begin
                        if (pair_hit(lo, wr_data, KEY_A, C_PROG))
                            step_n = S_PD;
                        else if (mode_q == M_READ && pair_hit(lo, wr_data, KEY_A, C_IDQ))
                            mode_n = M_IDQ;
                        else if (mode_q == M_READ && pair_hit(lo, wr_data, KEY_A, C_ERASE))
                            step_n = S_E3;
                    end
                    S_E3:   if (pair_hit(lo, wr_data, KEY_A, C_UNLK1)) step_n = S_E4;
                    S_E4:   if (pair_hit(lo, wr_data, KEY_B, C_UNLK2)) step_n = S_E5;
                    S_E5: begin
                        if (pair_hit(lo, wr_data, KEY_A, C_CHIP)) begin
                            mode_n = M_ERASE; ec_n = 1'b1; es_n = '0; start_n = 1'b1;
                        end else if (wr_data == C_SECT) begin
                            mode_n = M_ERASE; ec_n = 1'b0; es_n = hi; start_n = 1'b1;
                        end
                    end
                    default: step_n = S_IDLE;
                endcase
            end
        end else if (expire) begin
            step_n = S_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= M_READ;
            step_q  <= S_IDLE;
            pa_q    <= '0;
            pd_q    <= '0;
            ec_q    <= 1'b0;
            es_q    <= '0;
            start_q <= 1'b0;
        end else begin
            mode_q  <= mode_n;
            step_q  <= step_n;
            pa_q    <= pa_n;
            pd_q    <= pd_n;
            ec_q    <= ec_n;
            es_q    <= es_n;
            start_q <= start_n;
        end
    end

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst) start_q |=> !start_q); // R5
    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst) start_q |-> (mode_q == M_PROG || mode_q == M_ERASE || mode_q == M_SUSP_PROG)); // R6
    AST_GAP_ABORT: assert property (@(posedge clk) disable iff (rst) (step_q != S_IDLE && expire && !wr_stb) |=> step_q == S_IDLE); // R8
    AST_RESUME: assert property (@(posedge clk) disable iff (rst) (mode_q == M_SUSP && wr_stb && wr_data == C_SECT && step_q != S_PD) |=> mode_q == M_ERASE); // R7
    AST_IDQ_HOLD: assert property (@(posedge clk) disable iff (rst) (mode_q == M_IDQ && !(wr_stb && wr_data == C_RESET)) |=> mode_q == M_IDQ); // R4
    AST_SUSP_OUTSIDE: assert property (@(posedge clk) disable iff (rst) mode_q == M_SUSP_PROG |-> (!ec_q && pa_q[ADDR_W-1:LO_W] != es_q)); // R10

endmodule

// File: rtl/flcmd_idrom.sv
module flcmd_idrom
    import flcmd_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter bit TOP_BOOT = 1'b1,
    localparam int NSECT   = 1 << (ADDR_W - LO_W)
) (
    input  logic              idq_mode,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [NSECT-1:0]  sect_prot,
    output logic [DATA_W-1:0] as_data
);
    localparam logic [DATA_W-1:0] DEV_ID = TOP_BOOT ? ID_TOP : ID_BOT;

    logic [LO_W-1:0] ofs;
    assign ofs = rd_addr[LO_W-1:0];

    always_comb begin
        as_data = '0;
        if (idq_mode) begin
            unique case (ofs)
                12'h000: as_data = ID_MFR;
                12'h001: as_data = DEV_ID;
                12'h002: as_data = {{(DATA_W-1){1'b0}}, sect_prot[rd_addr[ADDR_W-1:LO_W]]};
                12'h003: as_data = ID_CONT;
                default: as_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/flcmd_decoder.sv
module flcmd_decoder
    import flcmd_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int TMO_CYC  = 12500,
    parameter bit TOP_BOOT = 1'b1,
    localparam int SW      = ADDR_W - LO_W,
    localparam int NSECT   = 1 << SW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              op_done,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [NSECT-1:0]  sect_prot,
    output logic [2:0]        mode,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [7:0]        prog_data,
    output logic              erase_chip,
    output logic [SW-1:0]     erase_sect,
    output logic              start_pulse,
    output logic [7:0]        as_data
);
    fl_mode_e mode_q;

    flcmd_seq #(.ADDR_W(ADDR_W), .TMO_CYC(TMO_CYC)) i_seq (
        .clk(clk), .rst(rst),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .op_done(op_done),
        .mode_q(mode_q), .pa_q(prog_addr), .pd_q(prog_data),
        .ec_q(erase_chip), .es_q(erase_sect), .start_q(start_pulse)
    );

    flcmd_idrom #(.ADDR_W(ADDR_W), .TOP_BOOT(TOP_BOOT)) i_idrom (
        .idq_mode(mode_q == M_IDQ),
        .rd_addr(rd_addr),
        .sect_prot(sect_prot),
        .as_data(as_data)
    );

    assign mode = mode_q;

    AST_IDQ_QUIET: assert property (@(posedge clk) disable iff (rst) mode_q != M_IDQ |-> as_data == 8'h00); // R2

endmodule

// File: tb/test_flcmd_decoder.sv
`timescale 1ns/1ps
module test_flcmd_decoder;
    localparam int TMO = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_stb = 1'b0;
    logic [16:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic op_done = 1'b0;
    logic [16:0] rd_addr = '0;
    logic [31:0] sect_prot = 32'h0000_0104;
    logic [2:0] mode;
    logic [16:0] prog_addr;
    logic [7:0] prog_data;
    logic erase_chip;
    logic [4:0] erase_sect;
    logic start_pulse;
    logic [7:0] as_data;

    int total = 0;
    int bad = 0;
    bit cmp_en = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    flcmd_decoder #(.ADDR_W(17), .TMO_CYC(TMO), .TOP_BOOT(1'b1)) i_flcmd_decoder (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .op_done(op_done), .rd_addr(rd_addr), .sect_prot(sect_prot),
        .mode(mode), .prog_addr(prog_addr), .prog_data(prog_data),
        .erase_chip(erase_chip), .erase_sect(erase_sect),
        .start_pulse(start_pulse), .as_data(as_data)
    );

    // behavioural reference model: a queue of the writes of the open sequence
    int m_mode = 0;
    bit m_start = 0;
    logic [16:0] m_pa = '0;
    logic [7:0] m_pd = '0;
    bit m_ec = 0;
    logic [4:0] m_es = '0;
    logic [24:0] q[$];
    int cyc = 0;
    int last_cyc = 0;

    function automatic bit fits(int k);
        logic [11:0] lo;
        logic [7:0] d;
        lo = q[k][19:8];
        d = q[k][7:0];
        case (k)
            0: return lo == 12'h555 && d == 8'hAA;
            1: return lo == 12'h2AA && d == 8'h55;
            2: return lo == 12'h555 && (d == 8'hA0 || (m_mode == 0 && (d == 8'h90 || d == 8'h80)));
            3: return lo == 12'h555 && d == 8'hAA;
            4: return lo == 12'h2AA && d == 8'h55;
            5: return (lo == 12'h555 && d == 8'h10) || d == 8'h30;
            default: return 0;
        endcase
    endfunction

    function automatic logic [7:0] exp_as(int md, logic [16:0] ra);
        if (md != 1) return 8'h00;
        case (ra[11:0])
            12'h000: return 8'h37;
            12'h001: return 8'hA1;
            12'h002: return {7'b0, sect_prot[ra[16:12]]};
            12'h003: return 8'h7F;
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        cyc++;
        m_start = 0;
        if (rst) begin
            m_mode = 0; m_pa = '0; m_pd = '0; m_ec = 0; m_es = '0;
            q.delete();
        end else if (op_done && (m_mode == 2 || m_mode == 3)) begin
            m_mode = 0; q.delete();
        end else if (op_done && m_mode == 5) begin
            m_mode = 4; q.delete();
        end else if (wr_stb) begin
            if (q.size() != 0 && cyc - last_cyc > TMO) q.delete();
            last_cyc = cyc;
            if (q.size() == 3 && q[2][7:0] == 8'hA0) begin
                if (m_mode == 0 || (m_mode == 4 && !m_ec && wr_addr[16:12] != m_es)) begin
                    m_mode = (m_mode == 0) ? 2 : 5;
                    m_pa = wr_addr; m_pd = wr_data; m_start = 1;
                end
                q.delete();
            end else if (wr_data == 8'hF0) begin
                q.delete();
                if (m_mode == 1) m_mode = 0;
            end else if (m_mode == 3) begin
                if (wr_data == 8'hB0) m_mode = 4;
            end else if (m_mode == 4 && wr_data == 8'h30) begin
                m_mode = 3; q.delete();
            end else if (m_mode == 0 || m_mode == 4) begin
                q.push_back({wr_addr, wr_data});
                if (!fits(q.size() - 1)) q.delete();
                else if (q.size() == 3 && wr_data == 8'h90) begin
                    m_mode = 1; q.delete();
                end else if (q.size() == 6) begin
                    m_mode = 3; m_start = 1;
                    if (wr_data == 8'h10 && wr_addr[11:0] == 12'h555) begin m_ec = 1; m_es = '0; end
                    else begin m_ec = 0; m_es = wr_addr[16:12]; end
                    q.delete();
                end
            end
        end
    end

    always @(posedge clk) begin
        #1;
        if (cmp_en) begin
            total++;
            if (mode !== m_mode[2:0] || start_pulse !== m_start || prog_addr !== m_pa ||
                prog_data !== m_pd || erase_chip !== m_ec || erase_sect !== m_es ||
                as_data !== exp_as(m_mode, rd_addr)) begin
                bad++;
                $display("FAIL %s model cycle %0d: mode=%0d/%0d start=%0b/%0b pa=%h/%h pd=%h/%h ec=%0b/%0b es=%h/%h as=%h/%h",
                         cur_req, cyc, mode, m_mode, start_pulse, m_start, prog_addr, m_pa, prog_data, m_pd,
                         erase_chip, m_ec, erase_sect, m_es, as_data, exp_as(m_mode, rd_addr));
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [16:0] a, logic [7:0] d);
        @(negedge clk); wr_addr = a; wr_data = d; wr_stb = 1'b1;
        @(negedge clk); wr_stb = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic unlock(logic [4:0] hi);
        wr({hi, 12'h555}, 8'hAA);
        wr({hi, 12'h2AA}, 8'h55);
    endtask

    task automatic done_pulse();
        @(negedge clk); op_done = 1'b1;
        @(negedge clk); op_done = 1'b0;
    endtask

    task automatic rd(logic [16:0] a);
        @(negedge clk); rd_addr = a; #0.5;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        cmp_en = 1;
        idle(1);
        cur_req = "R1";
        chk("R1 mode", mode, 0);
        chk("R1 start", start_pulse, 0);
        chk("R1 as_data", as_data, 8'h00);
        rst = 1'b0;
        idle(2);

        cur_req = "R2";
        unlock(5'h00); wr(17'h00555, 8'h90);
        chk("R2 mode", mode, 1);
        rd(17'h00000); chk("R2 mfr", as_data, 8'h37);
        rd(17'h1F001); chk("R2 dev", as_data, 8'hA1);
        rd(17'h00003); chk("R2 cont", as_data, 8'h7F);
        rd(17'h00004); chk("R2 other", as_data, 8'h00);
        rd(17'h00100); chk("R2 wide ofs", as_data, 8'h00);

        cur_req = "R3";
        rd({5'd2, 12'h002}); chk("R3 prot", as_data, 8'h01);
        rd({5'd3, 12'h002}); chk("R3 unprot", as_data, 8'h00);
        rd({5'd8, 12'h002}); chk("R3 prot8", as_data, 8'h01);

        cur_req = "R4";
        wr(17'h00555, 8'hAA); chk("R4 ignored", mode, 1);
        wr(17'h01234, 8'hF0); chk("R4 exit", mode, 0);
        rd(17'h00000); chk("R2 read mode", as_data, 8'h00);

        cur_req = "R5";
        unlock(5'h1F); wr(17'h1F555, 8'hA0); wr(17'h0ABCD, 8'h5A);
        chk("R5 mode", mode, 2);
        chk("R5 start", start_pulse, 1);
        chk("R5 addr", prog_addr, 17'h0ABCD);
        chk("R5 data", prog_data, 8'h5A);
        idle(1); chk("R5 start once", start_pulse, 0);
        wr(17'h00555, 8'hAA); chk("R5 busy ignores", mode, 2);
        cur_req = "R11";
        done_pulse(); chk("R11 prog done", mode, 0);
        done_pulse(); chk("R11 ignored in read", mode, 0);

        cur_req = "R6";
        unlock(5'h00); wr(17'h00555, 8'h80); unlock(5'h00); wr(17'h00555, 8'h10);
        chk("R6 chip mode", mode, 3);
        chk("R6 chip flag", erase_chip, 1);
        chk("R6 start", start_pulse, 1);
        done_pulse(); chk("R11 erase done", mode, 0);
        unlock(5'h00); wr(17'h00555, 8'h80); unlock(5'h00); wr(17'h0B123, 8'h30);
        chk("R6 sect mode", mode, 3);
        chk("R6 sect flag", erase_chip, 0);
        chk("R6 sect", erase_sect, 5'h0B);

        cur_req = "R7";
        wr(17'h00777, 8'hB0); chk("R7 suspend", mode, 4);

        cur_req = "R10";
        unlock(5'h00); wr(17'h00555, 8'hA0); wr(17'h0B010, 8'h11);
        chk("R10 same sector", mode, 4);
        chk("R10 no start", start_pulse, 0);
        unlock(5'h00); wr(17'h00555, 8'hA0); wr(17'h03020, 8'h22);
        chk("R10 other sector", mode, 5);
        chk("R10 start", start_pulse, 1);
        chk("R10 addr", prog_addr, 17'h03020);
        done_pulse(); chk("R10 back to susp", mode, 4);
        done_pulse(); chk("R11 ignored in susp", mode, 4);

        cur_req = "R7";
        wr(17'h00999, 8'h30); chk("R7 resume", mode, 3);

        cur_req = "R11";
        @(negedge clk); wr_addr = 17'h00555; wr_data = 8'hB0; wr_stb = 1'b1; op_done = 1'b1;
        @(negedge clk); wr_stb = 1'b0; op_done = 1'b0;
        chk("R11 done beats suspend", mode, 0);

        cur_req = "R7";
        wr(17'h00000, 8'h30); chk("R7 lone resume in read", mode, 0);
        chk("R7 no start", start_pulse, 0);

        cur_req = "R9";
        wr(17'h00555, 8'hAA); wr(17'h002AA, 8'h54); wr(17'h00555, 8'h90);
        chk("R9 mismatch", mode, 0);
        unlock(5'h15); wr(17'h15555, 8'h90); chk("R9 high bits ignored", mode, 1);
        wr(17'h00000, 8'hF0);
        cur_req = "R4";
        unlock(5'h00); wr(17'h00AAA, 8'hF0); wr(17'h00555, 8'h90);
        chk("R4 reset mid sequence", mode, 0);

        cur_req = "R8";
        wr(17'h00555, 8'hAA); idle(TMO - 2);
        wr(17'h002AA, 8'h55); idle(TMO - 2);
        wr(17'h00555, 8'h90);
        chk("R8 gap at limit", mode, 1);
        wr(17'h00000, 8'hF0);
        wr(17'h00555, 8'hAA); idle(TMO - 1);
        wr(17'h002AA, 8'h55); wr(17'h00555, 8'h90);
        chk("R8 gap over limit", mode, 0);

        idle(3);
        cmp_en = 0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule